// File: doc/BRIEF.md
# Debug trigger chaining unit

This block watches ten hardware debug triggers and decides, once per cycle, whether a breakpoint trap is requested. It also decides whether that trap is taken at the current instruction or at the next one. The triggers form five fixed pairs, and each pair draws on fixed address sources. Each trigger compares a 64-bit programmed value against the address from its source: the fetch PC, the load address or the store address. The trigger's own configuration sets the kind of comparison, and an enable bit gates the trigger.

Within a pair, a chain setting makes the two triggers act as one condition. A chained pair fires only when both members match in the same cycle and both have the same timing setting. If their timing settings differ, the chained pair never fires. An unchained trigger fires on its own match. The results are registered, so the trap request appears one cycle after the addresses are presented.

Configuration arrives on two write strobes, one for fetch-sourced triggers and one for memory-sourced triggers. Both strobes share one data bus. A write is always accepted in the cycle its strobe is high, so the port has no back-pressure and no ready signal. The source inputs are per-cycle samples qualified by their valid bits and are never stalled. The outputs are plain per-cycle flags.

Top module: `trig_chain_unit`

## Requirements
- R1: After reset every trigger configuration is zero: disabled, unchained, timing 0, match type 0 and compare value 0. All outputs are low, and no trigger fires even when every source is valid with address 0.
- R2: Fetch index values 0, 1, 2 and 3 write triggers 0, 1, 6 and 8. Memory index values 0 to 5 write triggers 2, 3, 4, 5, 7 and 9. Memory index values 6 and 7 change no trigger. A write stores all the data bus fields: enable, match type, select, timing, action, chain and compare value.
- R3: A trigger matches only when its enable bit is 1 and its source valid bit is 1. The comparison against its source address is unsigned: type 0 requires the address to equal the compare value, type 2 requires it to be greater than or equal to the compare value, and type 3 requires it to be less than the compare value. Type 1 never matches.
- R4: Pair sources are fixed. Pair 0 uses fetch and fetch, pair 1 store and store, pair 2 load and load, pair 3 fetch and store, and pair 4 fetch and load. Pair p holds triggers 2p and 2p+1. No address from any other source can make a trigger match.
- R5: In an unchained pair, each matching trigger fires alone with its own timing. Timing 0 raises `hit_now` and timing 1 raises `hit_next`.
- R6: A pair is chained when the chain bit of either member is 1. A chained pair fires only when both members match in the same cycle, and it then uses their common timing.
- R7: A chained pair whose members have different timing bits never fires.
- R8: The chain bits of the store/store pair (pair 1) have no effect, so its triggers always behave as unchained.
- R9: A trigger whose action bit is 1 never fires and never counts as a match for chaining.
- R10: `hit_now`, `hit_next` and `group_hit` are registered. They reflect the sources presented in the previous cycle and drop the cycle after the sources go idle. `group_hit[p]` is 1 when pair p fired with either timing.
- R11: A trigger whose select bit is 1 never matches, because data-value comparison is not provided.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_fetch_valid | input | 1 | Write strobe for a fetch-sourced trigger |
| cfg_fetch_idx | input | 2 | Fetch trigger index |
| cfg_mem_valid | input | 1 | Write strobe for a load- or store-sourced trigger |
| cfg_mem_idx | input | 3 | Memory trigger index |
| cfg_enable | input | 1 | Write data: enable |
| cfg_match_type | input | 2 | Write data: comparison kind |
| cfg_select | input | 1 | Write data: select (1 = data compare, never matches) |
| cfg_timing | input | 1 | Write data: 0 = current, 1 = next instruction |
| cfg_action | input | 1 | Write data: action (1 = no breakpoint) |
| cfg_chain | input | 1 | Write data: chain request |
| cfg_compare | input | 64 | Write data: compare value |
| fetch_valid | input | 1 | Fetch PC is valid this cycle |
| fetch_pc | input | 64 | Fetch PC |
| load_valid | input | 1 | Load address is valid this cycle |
| load_addr | input | 64 | Load address |
| store_valid | input | 1 | Store address is valid this cycle |
| store_addr | input | 64 | Store address |
| hit_now | output | 1 | Trap requested at the current instruction |
| hit_next | output | 1 | Trap requested at the next instruction |
| group_hit | output | 5 | Per-pair fire flags |

## Verification
The hardest cases to reach are the chained mixed-source pairs. A fetch/store pair fires only when a fetch PC and a store address hit their compare values in the same cycle. A load/load pair whose members both match must still stay silent, because their timing settings differ. The stimulus programs the triggers first so that such a pair is armed. Each vector then presents several sources at once, and other vectors present only one member's source or an address one below a bound, so the pair is also exercised just short of firing. Directed tests then rewrite one trigger to cover select, action, match type 1, the enable gate and the unused memory index values.

// File: rtl/trig_pkg.sv
package trig_pkg;
  localparam int ADDR_W     = 64;
  localparam int NUM_GROUPS = 5;
  localparam int NUM_TRIG   = 2 * NUM_GROUPS;

  typedef enum logic [1:0] {
    SRC_FETCH = 2'd0,
    SRC_STORE = 2'd1,
    SRC_LOAD  = 2'd2
  } trig_src_e;

  typedef enum logic [1:0] {
    MT_EQ   = 2'd0,
    MT_NONE = 2'd1,
    MT_GE   = 2'd2,
    MT_LT   = 2'd3
  } match_type_e;

  typedef struct packed {
    logic              en;
    logic [1:0]        mtype;
    logic              sel;
    logic              timing;
    logic              action;
    logic              chain;
    logic [ADDR_W-1:0] cmp;
  } trig_cfg_t;

  // Fixed source of each trigger slot.
  function automatic trig_src_e trig_src(input int k);
    case (k)
      0, 1:    return SRC_FETCH;
      2, 3:    return SRC_STORE;
      4, 5:    return SRC_LOAD;
      6:       return SRC_FETCH;
      7:       return SRC_STORE;
      8:       return SRC_FETCH;
      default: return SRC_LOAD;
    endcase
  endfunction

  function automatic int fetch_count(input int upto);
    int n = 0;
    for (int i = 0; i < upto; i++)
      if (trig_src(i) == SRC_FETCH) n++;
    return n;
  endfunction

  function automatic int mem_count(input int upto);
    return upto - fetch_count(upto);
  endfunction

  // A pair made of two store triggers may not chain.
  function automatic bit chain_ok(input int g);
    return !(trig_src(2 * g) == SRC_STORE && trig_src(2 * g + 1) == SRC_STORE);
  endfunction

  localparam int NUM_FETCH = fetch_count(NUM_TRIG);
  localparam int NUM_MEM   = mem_count(NUM_TRIG);
  localparam int FIDX_W    = $clog2(NUM_FETCH);
  localparam int MIDX_W    = $clog2(NUM_MEM);
endpackage

// File: rtl/trig_cfg_regs.sv
module trig_cfg_regs
  import trig_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       fetch_we,
  input  logic [FIDX_W-1:0]          fetch_idx,
  input  logic                       mem_we,
  input  logic [MIDX_W-1:0]          mem_idx,
  input  trig_cfg_t                  wdata,
  output trig_cfg_t [NUM_TRIG-1:0]   cfg_q
);
  for (genvar k = 0; k < NUM_TRIG; k++) begin : g_slot
    localparam trig_src_e SRC      = trig_src(k);
    localparam int        ORD      = (SRC == SRC_FETCH) ? fetch_count(k) : mem_count(k);
    localparam bit        CAN_CHAIN = chain_ok(k / 2);

    logic      wr_sel;
    trig_cfg_t nxt;
    trig_cfg_t q;

    if (SRC == SRC_FETCH) begin : g_fidx
      assign wr_sel = fetch_we && (fetch_idx == FIDX_W'(ORD));
    end else begin : g_midx
      assign wr_sel = mem_we && (mem_idx == MIDX_W'(ORD));
    end

    always_comb begin
      nxt = wdata;
      if (!CAN_CHAIN) nxt.chain = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q <= '0;
      else if (wr_sel) q <= nxt;
    end

    assign cfg_q[k] = q;
  end
endmodule

// File: rtl/trig_match.sv
module trig_match
  import trig_pkg::*;
(
  input  logic              en,
  input  logic [1:0]        mtype,
  input  logic              sel,
  input  logic              action,
  input  logic [ADDR_W-1:0] cmp,
  input  logic              src_valid,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  logic cmp_ok;

  always_comb begin
    case (match_type_e'(mtype))
      MT_EQ:   cmp_ok = (addr == cmp);
      MT_GE:   cmp_ok = (addr >= cmp);
      MT_LT:   cmp_ok = (addr < cmp);
      default: cmp_ok = 1'b0;
    endcase
    hit = en && !sel && !action && src_valid && cmp_ok;
  end
endmodule

// File: rtl/trig_pair_eval.sv
module trig_pair_eval (
  input  logic hit_lo,
  input  logic hit_hi,
  input  logic tim_lo,
  input  logic tim_hi,
  input  logic chained,
  output logic fire_now,
  output logic fire_next
);
  logic both;

  always_comb begin
    both = hit_lo && hit_hi && (tim_lo == tim_hi);
    if (chained) begin
      fire_now  = both && !tim_lo;
      fire_next = both && tim_lo;
    end else begin
      fire_now  = (hit_lo && !tim_lo) || (hit_hi && !tim_hi);
      fire_next = (hit_lo && tim_lo) || (hit_hi && tim_hi);
    end
  end
endmodule

// File: rtl/trig_chain_unit.sv
module trig_chain_unit
  import trig_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_fetch_valid,
  input  logic [FIDX_W-1:0]     cfg_fetch_idx,
  input  logic                  cfg_mem_valid,
  input  logic [MIDX_W-1:0]     cfg_mem_idx,
  input  logic                  cfg_enable,
  input  logic [1:0]            cfg_match_type,
  input  logic                  cfg_select,
  input  logic                  cfg_timing,
  input  logic                  cfg_action,
  input  logic                  cfg_chain,
  input  logic [ADDR_W-1:0]     cfg_compare,
  input  logic                  fetch_valid,
  input  logic [ADDR_W-1:0]     fetch_pc,
  input  logic                  load_valid,
  input  logic [ADDR_W-1:0]     load_addr,
  input  logic                  store_valid,
  input  logic [ADDR_W-1:0]     store_addr,
  output logic                  hit_now,
  output logic                  hit_next,
  output logic [NUM_GROUPS-1:0] group_hit
);
  trig_cfg_t                 wdata;
  trig_cfg_t [NUM_TRIG-1:0]  cfg_q;
  logic      [NUM_TRIG-1:0]  raw_hit;
  logic      [NUM_TRIG-1:0]  t_valid;
  logic      [ADDR_W-1:0]    t_addr [NUM_TRIG];
  logic      [NUM_GROUPS-1:0] fire_now;
  logic      [NUM_GROUPS-1:0] fire_next;

  always_comb begin
    wdata.en     = cfg_enable;
    wdata.mtype  = cfg_match_type;
    wdata.sel    = cfg_select;
    wdata.timing = cfg_timing;
    wdata.action = cfg_action;
    wdata.chain  = cfg_chain;
    wdata.cmp    = cfg_compare;
  end

  trig_cfg_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .fetch_we  (cfg_fetch_valid),
    .fetch_idx (cfg_fetch_idx),
    .mem_we    (cfg_mem_valid),
    .mem_idx   (cfg_mem_idx),
    .wdata     (wdata),
    .cfg_q     (cfg_q)
  );

  for (genvar k = 0; k < NUM_TRIG; k++) begin : g_trig
    localparam trig_src_e SRC = trig_src(k);
    if (SRC == SRC_FETCH) begin : g_f
      assign t_valid[k] = fetch_valid;
      assign t_addr[k]  = fetch_pc;
    end else if (SRC == SRC_STORE) begin : g_s
      assign t_valid[k] = store_valid;
      assign t_addr[k]  = store_addr;
    end else begin : g_l
      assign t_valid[k] = load_valid;
      assign t_addr[k]  = load_addr;
    end

    trig_match u_match (
      .en        (cfg_q[k].en),
      .mtype     (cfg_q[k].mtype),
      .sel       (cfg_q[k].sel),
      .action    (cfg_q[k].action),
      .cmp       (cfg_q[k].cmp),
      .src_valid (t_valid[k]),
      .addr      (t_addr[k]),
      .hit       (raw_hit[k])
    );
  end

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_pair
    trig_pair_eval u_pair (
      .hit_lo    (raw_hit[2*g]),
      .hit_hi    (raw_hit[2*g+1]),
      .tim_lo    (cfg_q[2*g].timing),
      .tim_hi    (cfg_q[2*g+1].timing),
      .chained   (cfg_q[2*g].chain | cfg_q[2*g+1].chain),
      .fire_now  (fire_now[g]),
      .fire_next (fire_next[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_now   <= 1'b0;
      hit_next  <= 1'b0;
      group_hit <= '0;
    end else begin
      hit_now   <= |fire_now;
      hit_next  <= |fire_next;
      group_hit <= fire_now | fire_next;
    end
  end
endmodule

// File: rtl/trig_chain_chk.sv
module trig_chain_chk
  import trig_pkg::*;
(
  input logic                      clk,
  input logic                      rst_n,
  input logic                      fetch_valid,
  input logic [ADDR_W-1:0]         fetch_pc,
  input logic                      load_valid,
  input logic [ADDR_W-1:0]         load_addr,
  input logic                      store_valid,
  input logic [ADDR_W-1:0]         store_addr,
  input trig_cfg_t [NUM_TRIG-1:0]  cfg,
  input logic [NUM_TRIG-1:0]       raw_hit,
  input logic                      hit_now,
  input logic                      hit_next,
  input logic [NUM_GROUPS-1:0]     group_hit
);
  AST_NO_SOURCE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(fetch_valid || load_valid || store_valid) |=> !hit_now && !hit_next && (group_hit == '0)); // R3

  for (genvar k = 0; k < NUM_TRIG; k++) begin : g_t
    localparam trig_src_e SRC = trig_src(k);
    logic              v;
    logic [ADDR_W-1:0] a;
    if (SRC == SRC_FETCH) begin : g_f
      assign v = fetch_valid;
      assign a = fetch_pc;
    end else if (SRC == SRC_STORE) begin : g_s
      assign v = store_valid;
      assign a = store_addr;
    end else begin : g_l
      assign v = load_valid;
      assign a = load_addr;
    end

    AST_ENABLE_GATES: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg[k].en |-> !raw_hit[k]); // R3
    AST_SELECT_GATES: assert property (@(posedge clk) disable iff (!rst_n)
      cfg[k].sel |-> !raw_hit[k]); // R11
    AST_ACTION_GATES: assert property (@(posedge clk) disable iff (!rst_n)
      cfg[k].action |-> !raw_hit[k]); // R9
    AST_TYPE1_NEVER: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg[k].mtype == 2'd1) |-> !raw_hit[k]); // R3
    AST_EQ_MISMATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg[k].mtype == 2'd0 && (!v || a != cfg[k].cmp)) |-> !raw_hit[k]); // R3
  end

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_p
    logic chained;
    assign chained = cfg[2*g].chain | cfg[2*g+1].chain;

    AST_CHAIN_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
      (chained && !(raw_hit[2*g] && raw_hit[2*g+1])) |=> !group_hit[g]); // R6
    AST_TIMING_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
      (chained && (cfg[2*g].timing != cfg[2*g+1].timing)) |=> !group_hit[g]); // R7
  end
endmodule

bind trig_chain_unit trig_chain_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .fetch_valid (fetch_valid),
  .fetch_pc    (fetch_pc),
  .load_valid  (load_valid),
  .load_addr   (load_addr),
  .store_valid (store_valid),
  .store_addr  (store_addr),
  .cfg         (cfg_q),
  .raw_hit     (raw_hit),
  .hit_now     (hit_now),
  .hit_next    (hit_next),
  .group_hit   (group_hit)
);

// File: tb/trig_chain_unit_tb.sv
module trig_chain_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_fetch_valid = 1'b0;
  logic [1:0]  cfg_fetch_idx = '0;
  logic        cfg_mem_valid = 1'b0;
  logic [2:0]  cfg_mem_idx = '0;
  logic        cfg_enable = 1'b0;
  logic [1:0]  cfg_match_type = '0;
  logic        cfg_select = 1'b0;
  logic        cfg_timing = 1'b0;
  logic        cfg_action = 1'b0;
  logic        cfg_chain = 1'b0;
  logic [63:0] cfg_compare = '0;
  logic        fetch_valid = 1'b0;
  logic [63:0] fetch_pc = '0;
  logic        load_valid = 1'b0;
  logic [63:0] load_addr = '0;
  logic        store_valid = 1'b0;
  logic [63:0] store_addr = '0;
  logic        hit_now;
  logic        hit_next;
  logic [4:0]  group_hit;

  int n_checks = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  trig_chain_unit u_dut (.*);

  typedef struct packed {
    logic [31:0] tag;
    logic        fv;
    logic [63:0] pc;
    logic        lv;
    logic [63:0] la;
    logic        sv;
    logic [63:0] sa;
    logic        now;
    logic        nxt;
    logic [4:0]  grp;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{"R6", 1'b1, 64'h1000, 1'b0, 64'h0,    1'b0, 64'h0,    1'b1, 1'b0, 5'b00001}, // chained pair 0, both
    '{"R6", 1'b1, 64'h2000, 1'b0, 64'h0,    1'b0, 64'h0,    1'b0, 1'b0, 5'b00000}, // only t1
    '{"R8", 1'b0, 64'h0,    1'b0, 64'h0,    1'b1, 64'h3000, 1'b1, 1'b0, 5'b00010}, // store chain ignored
    '{"R5", 1'b0, 64'h0,    1'b0, 64'h0,    1'b1, 64'h50,   1'b0, 1'b1, 5'b00010}, // t3 alone, next
    '{"R7", 1'b0, 64'h0,    1'b1, 64'h8800, 1'b0, 64'h0,    1'b0, 1'b0, 5'b00000}, // timing clash
    '{"R6", 1'b1, 64'h4000, 1'b0, 64'h0,    1'b1, 64'h5000, 1'b0, 1'b1, 5'b01000}, // fetch+store chain
    '{"R4", 1'b1, 64'h4000, 1'b0, 64'h0,    1'b0, 64'h0,    1'b0, 1'b0, 5'b00000}, // half of pair 3
    '{"R5", 1'b1, 64'h6000, 1'b1, 64'h7000, 1'b0, 64'h0,    1'b1, 1'b1, 5'b10000}, // unchained both
    '{"R3", 1'b0, 64'h6000, 1'b0, 64'h7000, 1'b0, 64'h3000, 1'b0, 1'b0, 5'b00000}, // no valids
    '{"R5", 1'b1, 64'h1000, 1'b1, 64'h7000, 1'b1, 64'h3000, 1'b1, 1'b1, 5'b10011}, // three pairs
    '{"R3", 1'b1, 64'h0FFF, 1'b0, 64'h0,    1'b1, 64'h100,  1'b0, 1'b0, 5'b00000}, // bounds miss
    '{"R3", 1'b0, 64'h0,    1'b0, 64'h0,    1'b1, 64'hFF,   1'b0, 1'b1, 5'b00010}, // lt just below
    '{"R4", 1'b0, 64'h0,    1'b1, 64'h4000, 1'b1, 64'h1000, 1'b0, 1'b0, 5'b00000}  // wrong sources
  };

  task automatic check(input string req, input logic en, input logic ex, input logic [4:0] eg);
    n_checks++;
    if (hit_now !== en || hit_next !== ex || group_hit !== eg) begin
      n_fail++;
      $display("FAIL %s: now=%0b next=%0b grp=%05b expected now=%0b next=%0b grp=%05b",
               req, hit_now, hit_next, group_hit, en, ex, eg);
    end
  endtask

  task automatic write_cfg(input bit is_mem, input int idx, input bit en, input logic [1:0] mt,
                           input bit sel, input bit tim, input bit act, input bit chn,
                           input logic [63:0] cmp);
    cfg_fetch_valid = !is_mem;
    cfg_mem_valid   = is_mem;
    cfg_fetch_idx   = 2'(idx);
    cfg_mem_idx     = 3'(idx);
    cfg_enable      = en;
    cfg_match_type  = mt;
    cfg_select      = sel;
    cfg_timing      = tim;
    cfg_action      = act;
    cfg_chain       = chn;
    cfg_compare     = cmp;
    @(negedge clk);
    cfg_fetch_valid = 1'b0;
    cfg_mem_valid   = 1'b0;
  endtask

  task automatic drive(input logic fv, input logic [63:0] pc, input logic lv, input logic [63:0] la,
                       input logic sv, input logic [63:0] sa);
    fetch_valid = fv; fetch_pc = pc;
    load_valid  = lv; load_addr = la;
    store_valid = sv; store_addr = sa;
  endtask

  task automatic one(input string req, input logic fv, input logic [63:0] pc, input logic lv,
                     input logic [63:0] la, input logic sv, input logic [63:0] sa,
                     input logic en, input logic ex, input logic [4:0] eg);
    drive(fv, pc, lv, la, sv, sa);
    @(negedge clk);
    check(req, en, ex, eg);
    drive(1'b0, 64'h0, 1'b0, 64'h0, 1'b0, 64'h0);
    @(negedge clk);
  endtask

  initial begin
    #(20 * 100000);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 in reset", 1'b0, 1'b0, 5'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", 1'b0, 1'b0, 5'b0);
    one("R1 zero config", 1'b1, 64'h0, 1'b1, 64'h0, 1'b1, 64'h0, 1'b0, 1'b0, 5'b0);

    // R2: program all ten triggers through both index spaces
    write_cfg(0, 0, 1, 2'd0, 0, 0, 0, 1, 64'h1000); // t0
    write_cfg(0, 1, 1, 2'd2, 0, 0, 0, 0, 64'h1000); // t1
    write_cfg(1, 0, 1, 2'd0, 0, 0, 0, 1, 64'h3000); // t2
    write_cfg(1, 1, 1, 2'd3, 0, 1, 0, 0, 64'h100);  // t3
    write_cfg(1, 2, 1, 2'd2, 0, 1, 0, 1, 64'h8000); // t4
    write_cfg(1, 3, 1, 2'd3, 0, 0, 0, 0, 64'h9000); // t5
    write_cfg(0, 2, 1, 2'd0, 0, 1, 0, 1, 64'h4000); // t6
    write_cfg(1, 4, 1, 2'd0, 0, 1, 0, 0, 64'h5000); // t7
    write_cfg(0, 3, 1, 2'd0, 0, 0, 0, 0, 64'h6000); // t8
    write_cfg(1, 5, 1, 2'd0, 0, 1, 0, 0, 64'h7000); // t9

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].fv, VECS[i].pc, VECS[i].lv, VECS[i].la, VECS[i].sv, VECS[i].sa);
      @(negedge clk);
      check($sformatf("%s vector %0d", VECS[i].tag, i), VECS[i].now, VECS[i].nxt, VECS[i].grp);
    end
    drive(1'b0, 64'h0, 1'b0, 64'h0, 1'b0, 64'h0);
    @(negedge clk);
    check("R10 drop after idle", 1'b0, 1'b0, 5'b0);

    // R10: output changes one clock after the sources, not before
    drive(1'b1, 64'h1000, 1'b0, 64'h0, 1'b0, 64'h0);
    #5;
    check("R10 before edge", 1'b0, 1'b0, 5'b0);
    @(negedge clk);
    check("R10 after edge", 1'b1, 1'b0, 5'b00001);
    drive(1'b0, 64'h0, 1'b0, 64'h0, 1'b0, 64'h0);
    @(negedge clk);

    write_cfg(0, 3, 1, 2'd0, 1, 0, 0, 0, 64'h6000);
    one("R11 select set", 1'b1, 64'h6000, 1'b0, 64'h0, 1'b0, 64'h0, 1'b0, 1'b0, 5'b0);
    write_cfg(0, 3, 1, 2'd0, 0, 0, 1, 0, 64'h6000);
    one("R9 action set", 1'b1, 64'h6000, 1'b0, 64'h0, 1'b0, 64'h0, 1'b0, 1'b0, 5'b0);
    write_cfg(0, 3, 1, 2'd1, 0, 0, 0, 0, 64'h6000);
    one("R3 type 1", 1'b1, 64'h6000, 1'b0, 64'h0, 1'b0, 64'h0, 1'b0, 1'b0, 5'b0);
    write_cfg(0, 3, 0, 2'd0, 0, 0, 0, 0, 64'h6000);
    one("R3 disabled", 1'b1, 64'h6000, 1'b0, 64'h0, 1'b0, 64'h0, 1'b0, 1'b0, 5'b0);
    write_cfg(0, 3, 1, 2'd0, 0, 0, 0, 0, 64'h6000);
    one("R2 rewrite t8", 1'b1, 64'h6000, 1'b0, 64'h0, 1'b0, 64'h0, 1'b1, 1'b0, 5'b10000);

    // R2: memory index 6 and 7 touch nothing
    write_cfg(1, 6, 1, 2'd0, 0, 0, 0, 0, 64'h0);
    write_cfg(1, 7, 1, 2'd0, 0, 0, 0, 0, 64'h0);
    one("R2 idx6/7 t9 kept", 1'b0, 64'h0, 1'b1, 64'h7000, 1'b0, 64'h0, 1'b0, 1'b1, 5'b10000);
    one("R2 idx6/7 no new", 1'b0, 64'h0, 1'b1, 64'h0, 1'b0, 64'h0, 1'b0, 1'b0, 5'b0);

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule